// File: doc/BRIEF.md
# Pin-Clocked One-Time Memory Programming Controller

This block lets an external programmer write and read back a one-time program memory of 1002 ten-bit words without any address pins. Four mode pins select what the block does. A slow strobe pin, sampled on the system clock, walks an internal address counter through the array. Data crosses an 8-bit bus. The block drives the bus only when reading back. In every other mode it releases the bus and samples it.

Each word passes over the bus in two halves, and the phase of the four-pulse address cycle selects the half. When the programmer enters write mode, the block captures the bus byte and sends one write strobe of fixed width, counted in system clocks, to the array port. The strobe carries that byte, the half select and the address. In read-back mode the block shows the stored half that matches the current phase. The programmer advances the address with further strobe pulses.

Top module: `otp_prog_if`

## Requirements
- R1: After reset the bus is released (`bus_oe`=0, `bus_out`=0), `mem_we` is 0, and the address is 0. Mode pins are written as {MD3,MD2,MD1,MD0}. 0101 clears, 1110 writes, 1100 reads back, 1101 and 1111 inhibit, and every other code idles.
- R2: While clear mode is held, the address and the pulse phase are both forced to 0.
- R3: In write or read-back mode, each falling edge of the strobe pin advances the phase modulo 4. The address rises by exactly one on the falling edge that moves the phase from 2 to 3, which is the third pulse of a cycle.
- R4: In inhibit or idle mode, strobe pulses change neither the address nor the phase.
- R5: The address stops at WORDS-1 (1001) and stays there through further pulses until a clear.
- R6: `bus_oe` is 1 only in read-back mode. In all other modes `bus_oe` is 0 and `bus_out` is 0.
- R7: In read-back mode, an even phase drives stored bits 7:0. An odd phase drives bits 9:8 on bus bits 1:0, with bus bits 7:2 at 0.
- R8: A transition into write mode raises `mem_we` for exactly PULSE_CYC system clocks. The default is 1000, which gives 1 ms at 1 MHz and sits inside the 0.95 to 1.05 ms window.
- R9: During the strobe, `mem_wdata` holds the bus byte captured at write entry. `mem_whi` equals bit 0 of the phase (1 = upper bits 9:8), and `mem_addr` is the current address.
- R10: Staying in write mode never starts a second strobe. Leaving write mode and re-entering it while a strobe runs does not extend or restart that strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_clk_pin | input | 1 | Address strobe pin (asynchronous) |
| md_pins | input | 4 | Mode pins, bit i = MDi (asynchronous) |
| bus_in | input | 8 | Data bus input side |
| bus_out | output | 8 | Data bus output value |
| bus_oe | output | 1 | Data bus drive enable |
| mem_addr | output | 10 | Array word address |
| mem_wdata | output | 8 | Byte to program |
| mem_whi | output | 1 | Half select: 0 = bits 7:0, 1 = bits 9:8 |
| mem_we | output | 1 | Programming strobe |
| mem_rdata | input | 10 | Array read word (combinational) |

## Verification
Random bytes are written into both halves of several consecutive words, and each half is read back at both phase parities. This separates a swapped or unmasked upper half from a correct one. Pulses are given one at a time, so the bench sees the address hold at phase 2 and step at phase 3, which exposes an increment on the wrong pulse. Directed cases cover the rest: pulses in the inhibit and idle codes, a clear in the middle of a cycle, a long pulse train into saturation, and leaving and re-entering write mode while a strobe runs. These cases tell the mode gating, the phase reset, the saturation limit and the single-strobe rule apart.

// File: rtl/otp_pkg.sv
package otp_pkg;

  typedef enum logic [2:0] {
    MODE_IDLE,
    MODE_CLEAR,
    MODE_WRITE,
    MODE_VERIFY,
    MODE_INHIBIT
  } otp_mode_t;

  // pins are {MD3,MD2,MD1,MD0}
  function automatic otp_mode_t decode_mode(input logic [3:0] md);
    case (md)
      4'b0101: decode_mode = MODE_CLEAR;
      4'b1110: decode_mode = MODE_WRITE;
      4'b1100: decode_mode = MODE_VERIFY;
      4'b1101,
      4'b1111: decode_mode = MODE_INHIBIT;
      default: decode_mode = MODE_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/otp_mode_sync.sv
module otp_mode_sync
  import otp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] md_pins,
  output otp_mode_t  mode
);

  logic [3:0] stage_q [SYNC_STAGES];

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= '0;
        else     stage_q[0] <= md_pins;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= '0;
        else     stage_q[g] <= stage_q[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) mode <= MODE_IDLE;
    else     mode <= decode_mode(stage_q[SYNC_STAGES-1]);
  end

endmodule

// File: rtl/otp_addr_seq.sv
module otp_addr_seq
  import otp_pkg::*;
#(
  parameter int WORDS       = 1002,
  parameter int SYNC_STAGES = 2,
  localparam int AW         = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clk_pin,
  input  otp_mode_t     mode,
  output logic [AW-1:0] addr,
  output logic [1:0]    phase
);

  localparam logic [AW-1:0] LAST = AW'(WORDS - 1);

  logic [SYNC_STAGES-1:0] pin_sync;
  logic                   pin_prev;
  logic                   pin_fall;
  logic                   counting;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_sync <= '0;
      pin_prev <= 1'b0;
    end else begin
      pin_sync <= {pin_sync[SYNC_STAGES-2:0], clk_pin};
      pin_prev <= pin_sync[SYNC_STAGES-1];
    end
  end

  assign pin_fall = pin_prev & ~pin_sync[SYNC_STAGES-1];
  assign counting = (mode == MODE_WRITE) || (mode == MODE_VERIFY);

  always_ff @(posedge clk) begin
    if (rst || mode == MODE_CLEAR) begin
      addr  <= '0;
      phase <= '0;
    end else if (pin_fall && counting) begin
      phase <= phase + 2'd1;
      if (phase == 2'd2 && addr != LAST) addr <= addr + 1'b1;
    end
  end

  assert_clear_R2: assert property (@(posedge clk) disable iff (rst)
    mode == MODE_CLEAR |=> (addr == '0 && phase == '0));

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_INHIBIT || mode == MODE_IDLE) |=> ($stable(addr) && $stable(phase)));

  assert_step_R3: assert property (@(posedge clk) disable iff (rst)
    addr != $past(addr) |-> (addr == $past(addr) + 1'b1 || addr == '0));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    addr <= LAST);

endmodule

// File: rtl/otp_strobe_timer.sv
module otp_strobe_timer
  import otp_pkg::*;
#(
  parameter int PULSE_CYC = 1000,
  parameter int AW        = 10,
  parameter int BUS_W     = 8,
  localparam int CW       = $clog2(PULSE_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  otp_mode_t        mode,
  input  logic [AW-1:0]    addr,
  input  logic             phase_lsb,
  input  logic [BUS_W-1:0] bus_in,
  output logic             we,
  output logic [AW-1:0]    waddr,
  output logic [BUS_W-1:0] wdata,
  output logic             whi
);

  logic          was_write;
  logic [CW-1:0] cnt;
  logic          in_write;
  logic          start;

  assign in_write = (mode == MODE_WRITE);
  assign start    = in_write && !was_write && !we;

  always_ff @(posedge clk) begin
    if (rst) begin
      was_write <= 1'b0;
      we        <= 1'b0;
      cnt       <= '0;
      waddr     <= '0;
      wdata     <= '0;
      whi       <= 1'b0;
    end else begin
      was_write <= in_write;
      if (start) begin
        we    <= 1'b1;
        cnt   <= '0;
        waddr <= addr;
        wdata <= bus_in;
        whi   <= phase_lsb;
      end else if (we) begin
        if (cnt == CW'(PULSE_CYC - 1)) we <= 1'b0;
        cnt <= cnt + 1'b1;
      end
    end
  end

  // independent width and restart watchers
  logic [CW:0] chk_len;
  logic        chk_fired;

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_len   <= '0;
      chk_fired <= 1'b0;
    end else begin
      chk_len   <= we ? chk_len + 1'b1 : '0;
      chk_fired <= in_write && (chk_fired || we);
    end
  end

  assert_width_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(we) |-> chk_len == (CW+1)'(PULSE_CYC));

  assert_no_retrigger_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(we) |-> !chk_fired);

endmodule

// File: rtl/otp_bus_drv.sv
module otp_bus_drv
  import otp_pkg::*;
#(
  parameter int WORD_W = 10,
  parameter int BUS_W  = 8,
  localparam int HI_W  = WORD_W - BUS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  otp_mode_t         mode,
  input  logic              phase_lsb,
  input  logic [WORD_W-1:0] rdata,
  output logic [BUS_W-1:0]  bus_out,
  output logic              bus_oe
);

  logic [BUS_W-1:0] upper_ext;
  assign upper_ext = {{(BUS_W-HI_W){1'b0}}, rdata[WORD_W-1:BUS_W]};

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_out <= '0;
      bus_oe  <= 1'b0;
    end else begin
      bus_oe <= (mode == MODE_VERIFY);
      if (mode == MODE_VERIFY) bus_out <= phase_lsb ? upper_ext : rdata[BUS_W-1:0];
      else                     bus_out <= '0;
    end
  end

  assert_upper_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_oe && $past(phase_lsb)) |-> bus_out[BUS_W-1:HI_W] == '0);

endmodule

// File: rtl/otp_prog_if.sv
module otp_prog_if
  import otp_pkg::*;
#(
  parameter int WORDS       = 1002,
  parameter int WORD_W      = 10,
  parameter int BUS_W       = 8,
  parameter int PULSE_CYC   = 1000,
  parameter int SYNC_STAGES = 2,
  localparam int AW         = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prog_clk_pin,
  input  logic [3:0]        md_pins,
  input  logic [BUS_W-1:0]  bus_in,
  output logic [BUS_W-1:0]  bus_out,
  output logic              bus_oe,
  output logic [AW-1:0]     mem_addr,
  output logic [BUS_W-1:0]  mem_wdata,
  output logic              mem_whi,
  output logic              mem_we,
  input  logic [WORD_W-1:0] mem_rdata
);

  otp_mode_t      mode;
  logic [AW-1:0]  addr;
  logic [AW-1:0]  waddr;
  logic [1:0]     phase;

  otp_mode_sync #(.SYNC_STAGES(SYNC_STAGES)) u_mode (
    .clk(clk), .rst(rst), .md_pins(md_pins), .mode(mode)
  );

  otp_addr_seq #(.WORDS(WORDS), .SYNC_STAGES(SYNC_STAGES)) u_seq (
    .clk(clk), .rst(rst), .clk_pin(prog_clk_pin), .mode(mode),
    .addr(addr), .phase(phase)
  );

  otp_strobe_timer #(.PULSE_CYC(PULSE_CYC), .AW(AW), .BUS_W(BUS_W)) u_tmr (
    .clk(clk), .rst(rst), .mode(mode), .addr(addr), .phase_lsb(phase[0]),
    .bus_in(bus_in), .we(mem_we), .waddr(waddr), .wdata(mem_wdata), .whi(mem_whi)
  );

  otp_bus_drv #(.WORD_W(WORD_W), .BUS_W(BUS_W)) u_bus (
    .clk(clk), .rst(rst), .mode(mode), .phase_lsb(phase[0]),
    .rdata(mem_rdata), .bus_out(bus_out), .bus_oe(bus_oe)
  );

  assign mem_addr = mem_we ? waddr : addr;

  logic unused_phase_msb;
  assign unused_phase_msb = phase[1];

endmodule

// File: tb/test_otp_prog_if.sv
module test_otp_prog_if;
  localparam int CLK_PERIOD = 10;
  localparam int WORDS  = 1002;
  localparam int WW     = 10;
  localparam int BW     = 8;
  localparam int PULSE  = 40;
  localparam int AW     = $clog2(WORDS);
  localparam logic [3:0] MD_CLR = 4'b0101, MD_WR = 4'b1110, MD_VF = 4'b1100;
  localparam logic [3:0] MD_INH = 4'b1101, MD_INH2 = 4'b1111, MD_IDLE = 4'b0000;

  logic clk = 0, rst = 1, pin = 0;
  logic [3:0] md_pins = MD_IDLE;
  logic [BW-1:0] bus_in = '0, bus_out, mem_wdata;
  logic bus_oe, mem_whi, mem_we;
  logic [AW-1:0] mem_addr;
  logic [WW-1:0] mem_rdata;

  int checks = 0, errors = 0;
  int exp_addr = 0, exp_ph = 0;
  logic [3:0] cur_md = MD_IDLE;
  logic [WW-1:0] arr [WORDS];
  logic [WW-1:0] exp_mem [WORDS];

  otp_prog_if #(.WORDS(WORDS), .WORD_W(WW), .BUS_W(BW), .PULSE_CYC(PULSE)) i_otp_prog_if (
    .clk(clk), .rst(rst), .prog_clk_pin(pin), .md_pins(md_pins), .bus_in(bus_in),
    .bus_out(bus_out), .bus_oe(bus_oe), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_whi(mem_whi), .mem_we(mem_we), .mem_rdata(mem_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural array
  assign mem_rdata = (int'(mem_addr) < WORDS) ? arr[mem_addr] : '0;
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WORDS; i++) arr[i] <= '0;
    end else if (mem_we) begin
      if (mem_whi) arr[mem_addr][WW-1:BW] <= mem_wdata[WW-BW-1:0];
      else         arr[mem_addr][BW-1:0]  <= mem_wdata;
    end
  end

  function automatic logic [BW-1:0] exp_bus(input int a, input int ph);
    if (ph % 2 == 1) return {{(2*BW-WW){1'b0}}, exp_mem[a][WW-1:BW]};
    return exp_mem[a][BW-1:0];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_mode(input logic [3:0] md);
    @(negedge clk);
    md_pins = md;
    cur_md  = md;
    if (md == MD_CLR) begin exp_addr = 0; exp_ph = 0; end
    repeat (8) @(negedge clk);
  endtask

  task automatic pulse();
    @(negedge clk); pin = 1;
    repeat (4) @(negedge clk);
    pin = 0;
    repeat (5) @(negedge clk);
    if (cur_md == MD_WR || cur_md == MD_VF) begin
      if (exp_ph == 2 && exp_addr < WORDS-1) exp_addr++;
      exp_ph = (exp_ph + 1) % 4;
    end
  endtask

  task automatic write_half(input logic [BW-1:0] b);
    logic [31:0] a0 = 0, h0 = 0, d0 = 0;
    int len = 0;
    bit seen = 0;
    bus_in = b;
    @(negedge clk); md_pins = MD_WR; cur_md = MD_WR;
    for (int i = 0; i < 30 && !seen; i++) begin
      @(negedge clk);
      if (mem_we) begin seen = 1; a0 = mem_addr; h0 = mem_whi; d0 = mem_wdata; end
    end
    chk("R8 strobe starts on write entry", seen, 1);
    chk("R6 bus released in write", {bus_oe, bus_out}, 0);
    while (mem_we && len < PULSE + 10) begin len++; @(negedge clk); end
    chk("R8 strobe width", len, PULSE);
    chk("R9 strobe address", a0, exp_addr);
    chk("R9 strobe half", h0, exp_ph % 2);
    chk("R9 strobe data", d0, b);
    if (exp_ph % 2 == 1) exp_mem[exp_addr][WW-1:BW] = b[WW-BW-1:0];
    else                 exp_mem[exp_addr][BW-1:0]  = b;
    set_mode(MD_INH);
  endtask

  task automatic check_read(input string req);
    chk({req, " oe"}, bus_oe, 1);
    chk({req, " data"}, bus_out, exp_bus(exp_addr, exp_ph));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [BW-1:0] lo, hi;
    int rises, highs;
    logic prev;
    for (int i = 0; i < WORDS; i++) exp_mem[i] = '0;
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 bus_oe after reset", bus_oe, 0);
    chk("R1 bus_out after reset", bus_out, 0);
    chk("R1 mem_we after reset", mem_we, 0);
    chk("R1 address after reset", mem_addr, 0);

    set_mode(MD_CLR);
    chk("R2 clear address", mem_addr, 0);
    set_mode(MD_INH);
    chk("R6 released in inhibit", bus_oe, 0);

    // random words, both halves
    for (int w = 0; w < 6; w++) begin
      lo = BW'($urandom);
      hi = BW'($urandom % 4);
      write_half(lo);
      set_mode(MD_VF);
      check_read("R7 low half");
      pulse();
      chk("R3 phase1 keeps address", mem_addr, exp_addr);
      write_half(hi);
      set_mode(MD_VF);
      check_read("R7 high half");
      pulse();
      chk("R3 phase2 keeps address", mem_addr, exp_addr);
      check_read("R7 even phase");
      pulse();
      chk("R3 third pulse steps address", mem_addr, exp_addr);
      check_read("R7 next word upper");
      pulse();
      chk("R3 cycle wraps", mem_addr, exp_addr);
      if ($urandom % 2 == 1) begin
        set_mode(($urandom % 2 == 1) ? MD_INH : MD_INH2);
        pulse(); pulse(); pulse();
        chk("R4 inhibit holds address", mem_addr, exp_addr);
        chk("R6 released in inhibit", bus_oe, 0);
      end
    end

    // idle code ignores pulses; phase held too
    set_mode(MD_VF);
    pulse();
    set_mode(MD_IDLE);
    pulse(); pulse(); pulse();
    chk("R4 idle holds address", mem_addr, exp_addr);
    chk("R6 released in idle", {bus_oe, bus_out}, 0);
    set_mode(MD_VF);
    check_read("R4 idle holds phase");

    // clear mid-cycle resets phase
    set_mode(MD_CLR);
    set_mode(MD_VF);
    check_read("R2 clear resets phase");
    chk("R2 clear resets address", mem_addr, 0);

    // retrigger protection
    set_mode(MD_INH);
    lo = BW'($urandom);
    bus_in = lo;
    rises = 0; highs = 0; prev = 0;
    @(negedge clk); md_pins = MD_WR; cur_md = MD_WR;
    for (int i = 0; i < 3*PULSE + 30; i++) begin
      @(negedge clk);
      if (i == 10) md_pins = MD_INH;
      if (i == 18) md_pins = MD_WR;
      if (mem_we && !prev) rises++;
      if (mem_we) highs++;
      prev = mem_we;
    end
    chk("R10 single strobe", rises, 1);
    chk("R10 width unchanged", highs, PULSE);
    exp_mem[exp_addr][BW-1:0] = lo;
    set_mode(MD_VF);
    check_read("R9 retrigger data stored");

    // saturation
    set_mode(MD_CLR);
    set_mode(MD_VF);
    for (int i = 0; i < 4*WORDS + 6; i++) pulse();
    chk("R5 saturates at last word", mem_addr, WORDS-1);
    chk("R5 bench model agrees", exp_addr, WORDS-1);
    set_mode(MD_CLR);
    chk("R5 clear after saturation", mem_addr, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule